// File: doc/BRIEF.md
# Dual Sub-frame Slow-time Doppler Unit

This block turns one radar frame of range-processed complex samples into Doppler spectra, one spectrum set per range bin. It first stores a whole frame, 32 chirps of 64 range bins each, in an internal buffer. It then walks the range bins in order. For each range bin it cuts the 32 slow-time samples into two independent groups of 16 chirps. Each group is tapered with a Hamming window and transformed with a 16-point discrete Fourier transform.

The two 16-bin spectra of a range bin are packed back to back into 32 output bins. Every output bin is tagged with its range index and packed bin index. When the final bin of the frame has left the block, a one-cycle completion pulse follows. The block then waits for the next frame-start pulse. Everything runs in one clock domain with a synchronous active-low reset.

Top module: `subframe_doppler`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `frame_done` are low.
- R2: Every input and output word carries Q in bits 31:16 and I in bits 15:0, each a 16-bit two's-complement value.
- R3: A `frame_start` pulse seen while idle opens accumulation, and the word offered in that same cycle is not stored. The next 2048 words with `in_valid` high fill the frame in chirp-major order: address = chirp*64 + range bin. `in_valid` may drop between words. Words offered while idle or while processing are ignored.
- R4: Slow-time sample n (0..15) of a sub-frame is scaled by w[n] = round(32767*(0.54 - 0.46*cos(2*pi*n/15))) and becomes sat16((x*w[n] + 2^14) >>> 15), separately for I and Q.
- R5: Twiddles are cos/sin(2*pi*m/16) in Q15, built from a quarter-wave table of four entries (32767, 30273, 23170, 12539) by symmetry. The cosine of m = 4 and m = 12 is 0, and sin(m) equals cos(m-4 mod 16).
- R6: Bin k of a sub-frame is A = sum over n of y[n]*(cos - j*sin)(2*pi*n*k/16), accumulated exactly. It is emitted as sat16((A + 2^16) >>> 17) for each of I and Q.
- R7: Outputs come range bin 0 to 63. Within a range bin they come packed bin 0 to 31: bins 0..15 are the spectrum of chirps 0..15, and bins 16..31 that of chirps 16..31 (k = bin - 16). `out_range` and `out_bin` tag each word.
- R8: A full-scale constant input (I = 32767, Q = -32768 on all chirps) yields I = 32767 and Q = -32768 in packed bins 0 and 16, with no wrap-around.
- R9: `frame_done` is high for exactly one cycle, the cycle after the last output word. After it the block is idle and accepts a new `frame_start`.
- R10: Inside one sub-frame, consecutive output words are exactly 17 clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 100 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| in_iq | input | 32 | Input sample, Q in 31:16, I in 15:0 |
| in_valid | input | 1 | Qualifies `in_iq` during accumulation |
| frame_start | input | 1 | Starts collection of a new frame when idle |
| out_iq | output | 32 | Doppler sample, Q in 31:16, I in 15:0 |
| out_valid | output | 1 | Qualifies `out_iq`, `out_range`, `out_bin` |
| out_range | output | 6 | Range bin of the current output word |
| out_bin | output | 5 | Packed Doppler bin of the current output word |
| frame_done | output | 1 | One-cycle pulse after the last output word |

## Verification
The results are not due at one fixed latency. The bench therefore checks each output word in the cycle its `out_valid` is seen, sampling on the falling edge. It compares the word against the next entry of a frame spectrum computed arithmetically before the frame starts. The cycle count from one word to the next within a sub-frame must be exactly 17. `frame_done` must be high in the very next sampled cycle after word 2047 and low in every other cycle. Any stray word taken while idle or busy would shift or corrupt the stored frame, so the bin-exact comparisons also catch violations of R3.

// File: rtl/sfd_pkg.sv
// Shared widths, types and the saturation helper for the sub-frame Doppler unit.
// Assumes 16-bit signed I/Q components and a fixed 16-point sub-frame length.
package sfd_pkg;
    localparam int SAMPLE_W = 16;
    localparam int SUB_LEN  = 16;
    localparam int SUB_AW   = $clog2(SUB_LEN);
    localparam int ACC_W    = 2 * SAMPLE_W + 8;
    localparam int WIDE_W   = 48;

    typedef struct packed {
        logic signed [SAMPLE_W-1:0] q;
        logic signed [SAMPLE_W-1:0] i;
    } iq_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACCUM, ST_LOAD, ST_MAC, ST_EMIT, ST_FINISH
    } ctl_state_t;

    // Clamp a wide signed value into the 16-bit sample range.
    function automatic logic signed [SAMPLE_W-1:0] sat16(input logic signed [WIDE_W-1:0] v);
        if (v > WIDE_W'(32767))
            return 16'sh7fff;
        else if (v < -WIDE_W'(32768))
            return 16'sh8000;
        else
            return v[SAMPLE_W-1:0];
    endfunction
endpackage

// File: rtl/frame_store.sv
// Frame buffer: one write port fed during accumulation, one registered read port.
// Assumes the caller never reads and writes the same word in one cycle.
module frame_store #(
    parameter int DEPTH  = 2048,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store an incoming word.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Registered read, one cycle of latency.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/taper_mult.sv
// Hamming taper: scales one complex sample by the Q15 coefficient for its
// slow-time position, rounding and saturating back to 16 bits.
// Assumes a 16-point symmetric window; positions 8..15 mirror 7..0.
module taper_mult
    import sfd_pkg::*;
(
    input  logic [SUB_AW-1:0] pos,
    input  iq_t               x,
    output iq_t               y
);
    logic [2:0]          half_idx;
    logic signed [16:0]  coef;
    logic signed [32:0]  prod_i, prod_q;

    // Pick the coefficient from the half table by mirroring the position.
    always_comb begin
        half_idx = pos[3] ? ~pos[2:0] : pos[2:0];
        case (half_idx)
            3'd0:    coef = 17'sd2621;
            3'd1:    coef = 17'sd3924;
            3'd2:    coef = 17'sd7608;
            3'd3:    coef = 17'sd13036;
            3'd4:    coef = 17'sd19270;
            3'd5:    coef = 17'sd25231;
            3'd6:    coef = 17'sd29888;
            default: coef = 17'sd32438;
        endcase
    end

    // Multiply, round half up, shift out the Q15 scale and clamp.
    always_comb begin
        prod_i = 33'($signed(x.i)) * 33'(coef);
        prod_q = 33'($signed(x.q)) * 33'(coef);
        y.i    = sat16(WIDE_W'((prod_i + 33'sd16384) >>> 15));
        y.q    = sat16(WIDE_W'((prod_q + 33'sd16384) >>> 15));
    end
endmodule

// File: rtl/twiddle_gen.sv
// Twiddle source: cos and sin of 2*pi*m/16 in Q15 from a four-entry
// quarter-wave cosine table, other quadrants by symmetry.
// Assumes a 16-point transform; m wraps modulo 16.
module twiddle_gen
    import sfd_pkg::*;
(
    input  logic [SUB_AW-1:0]         m,
    output logic signed [SAMPLE_W-1:0] cos_v,
    output logic signed [SAMPLE_W-1:0] sin_v
);
    // Quarter table, index 4 stands for the zero at ninety degrees.
    function automatic logic signed [SAMPLE_W-1:0] qtab(input logic [2:0] idx);
        case (idx)
            3'd0:    return 16'sd32767;
            3'd1:    return 16'sd30273;
            3'd2:    return 16'sd23170;
            3'd3:    return 16'sd12539;
            default: return 16'sd0;
        endcase
    endfunction

    // Fold a 16-step angle onto the quarter table.
    function automatic logic signed [SAMPLE_W-1:0] cos16(input logic [SUB_AW-1:0] a);
        logic [2:0] r;
        r = {1'b0, a[1:0]};
        case (a[3:2])
            2'd0:    return qtab(r);
            2'd1:    return -qtab(3'd4 - r);
            2'd2:    return -qtab(r);
            default: return qtab(3'd4 - r);
        endcase
    endfunction

    logic signed [34:0] mag_sq;

    // Cosine directly, sine as the cosine a quarter turn earlier.
    always_comb begin
        cos_v  = cos16(m);
        sin_v  = cos16(m - SUB_AW'(4));
        mag_sq = 35'(cos_v) * 35'(cos_v) + 35'(sin_v) * 35'(sin_v);
        assert_unit_circle_R5: assert (mag_sq <= 35'sd1073676289 + 35'sd65534 &&
                                       mag_sq >= 35'sd1073676289 - 35'sd65534);
    end
endmodule

// File: rtl/bin_accum.sv
// Complex multiply-accumulate for one Doppler bin: adds y*(cos - j*sin)
// each enabled cycle, exactly, and clears when asked.
// Assumes at most 16 terms, so ACC_W bits never overflow.
module bin_accum
    import sfd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      en,
    input  iq_t                       y,
    input  logic signed [SAMPLE_W-1:0] cos_v,
    input  logic signed [SAMPLE_W-1:0] sin_v,
    output logic signed [ACC_W-1:0]   acc_re,
    output logic signed [ACC_W-1:0]   acc_im
);
    logic signed [ACC_W-1:0] term_re, term_im;

    // Full-precision complex product with the conjugate twiddle.
    always_comb begin
        term_re = ACC_W'($signed(y.i) * cos_v) + ACC_W'($signed(y.q) * sin_v);
        term_im = ACC_W'($signed(y.q) * cos_v) - ACC_W'($signed(y.i) * sin_v);
    end

    // Accumulate while enabled, otherwise return to zero on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= acc_re + term_re;
            acc_im <= acc_im + term_im;
        end else if (clear) begin
            acc_re <= '0;
            acc_im <= '0;
        end
    end
endmodule

// File: rtl/subframe_doppler.sv
// Dual sub-frame Doppler unit. Collects a frame of CHIRPS x RANGE_BINS words,
// then per range bin windows and transforms each 16-chirp sub-frame and emits
// the packed bins with range/bin tags, followed by a one-cycle done pulse.
// Assumes chirp-major input order and CHIRPS a multiple of 16.
module subframe_doppler
    import sfd_pkg::*;
#(
    parameter int RANGE_BINS = 64,
    parameter int CHIRPS     = 32,
    parameter int OUT_SHIFT  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2*SAMPLE_W-1:0]         in_iq,
    input  logic                          in_valid,
    input  logic                          frame_start,
    output logic [2*SAMPLE_W-1:0]         out_iq,
    output logic                          out_valid,
    output logic [$clog2(RANGE_BINS)-1:0] out_range,
    output logic [$clog2(CHIRPS)-1:0]     out_bin,
    output logic                          frame_done
);
    localparam int DEPTH = RANGE_BINS * CHIRPS;
    localparam int AW    = $clog2(DEPTH);
    localparam int RW    = $clog2(RANGE_BINS);
    localparam int BW    = $clog2(CHIRPS);
    localparam int SUBS  = CHIRPS / SUB_LEN;
    localparam int SW    = (SUBS > 1) ? $clog2(SUBS) : 1;
    localparam int TW    = SUB_AW + 1;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (14 + OUT_SHIFT);

    ctl_state_t         state;
    logic [AW-1:0]      wr_count;
    logic [RW-1:0]      rbin;
    logic [SW-1:0]      sub;
    logic [TW-1:0]      tap;
    logic [SUB_AW-1:0]  kbin, nidx, tap_prev, tw_idx;
    logic [AW-1:0]      rd_addr;
    logic [2*SAMPLE_W-1:0] rd_data;
    iq_t                tapered, mac_in;
    iq_t                win_buf [SUB_LEN];
    logic signed [SAMPLE_W-1:0] tw_cos, tw_sin;
    logic signed [ACC_W-1:0]    acc_re, acc_im, rnd_re, rnd_im;
    logic signed [SAMPLE_W-1:0] emit_i, emit_q;
    logic               wr_en;

    assign wr_en = (state == ST_ACCUM) && in_valid;

    frame_store #(.DEPTH(DEPTH), .WIDTH(2 * SAMPLE_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_count),
        .wr_data (in_iq),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Read address: chirp of this sub-frame tap, at the current range bin.
    always_comb begin
        rd_addr  = AW'((int'(sub) * SUB_LEN + int'(tap[SUB_AW-1:0])) * RANGE_BINS + int'(rbin));
        tap_prev = SUB_AW'(tap - TW'(1));
    end

    taper_mult u_taper (
        .pos (tap_prev),
        .x   (rd_data),
        .y   (tapered)
    );

    // Capture windowed samples as they return from the buffer.
    always_ff @(posedge clk) begin
        if (state == ST_LOAD && tap != '0)
            win_buf[tap_prev] <= tapered;
    end

    // Select the MAC operand and its twiddle step n*k modulo 16.
    always_comb begin
        mac_in = win_buf[nidx];
        tw_idx = SUB_AW'(nidx * kbin);
    end

    twiddle_gen u_twiddle (
        .m     (tw_idx),
        .cos_v (tw_cos),
        .sin_v (tw_sin)
    );

    bin_accum u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state != ST_MAC),
        .en     (state == ST_MAC),
        .y      (mac_in),
        .cos_v  (tw_cos),
        .sin_v  (tw_sin),
        .acc_re (acc_re),
        .acc_im (acc_im)
    );

    // Scale the finished bin back to 16 bits with rounding and saturation.
    always_comb begin
        rnd_re = (acc_re + HALF_LSB) >>> (15 + OUT_SHIFT);
        rnd_im = (acc_im + HALF_LSB) >>> (15 + OUT_SHIFT);
        emit_i = sat16(WIDE_W'(rnd_re));
        emit_q = sat16(WIDE_W'(rnd_im));
    end

    // Frame sequencer: idle, accumulate, load, multiply-accumulate, emit, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            wr_count   <= '0;
            rbin       <= '0;
            sub        <= '0;
            tap        <= '0;
            kbin       <= '0;
            nidx       <= '0;
            out_iq     <= '0;
            out_valid  <= 1'b0;
            out_range  <= '0;
            out_bin    <= '0;
            frame_done <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frame_start) begin
                        state    <= ST_ACCUM;
                        wr_count <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (in_valid) begin
                        if (wr_count == AW'(DEPTH - 1)) begin
                            wr_count <= '0;
                            state    <= ST_LOAD;
                            rbin     <= '0;
                            sub      <= '0;
                            tap      <= '0;
                        end else begin
                            wr_count <= wr_count + 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    if (tap == TW'(SUB_LEN)) begin
                        state <= ST_MAC;
                        kbin  <= '0;
                        nidx  <= '0;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                ST_MAC: begin
                    nidx <= nidx + 1'b1;
                    if (nidx == SUB_AW'(SUB_LEN - 1))
                        state <= ST_EMIT;
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    out_iq    <= {emit_q, emit_i};
                    out_range <= rbin;
                    out_bin   <= BW'({sub, kbin});
                    if (kbin != SUB_AW'(SUB_LEN - 1)) begin
                        kbin  <= kbin + 1'b1;
                        nidx  <= '0;
                        state <= ST_MAC;
                    end else if (sub != SW'(SUBS - 1)) begin
                        sub   <= sub + 1'b1;
                        tap   <= '0;
                        state <= ST_LOAD;
                    end else if (rbin != RW'(RANGE_BINS - 1)) begin
                        rbin  <= rbin + 1'b1;
                        sub   <= '0;
                        tap   <= '0;
                        state <= ST_LOAD;
                    end else begin
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    frame_done <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Words are only counted into the buffer during accumulation.
    assert_ignore_outside_accum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACCUM) |=> $stable(wr_count));

    // The completion pulse lasts one cycle.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // The completion pulse directly follows the final bin of the last range bin.
    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> ($past(out_valid) && $past(out_bin) == BW'(CHIRPS - 1)
                        && $past(out_range) == RW'(RANGE_BINS - 1)));

    // Bins of one sub-frame leave 17 cycles apart in ascending order.
    assert_bin_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin[SUB_AW-1:0] != '0) |->
        ($past(out_valid, 17) && $past(out_bin, 17) == out_bin - 1'b1));
endmodule

// File: tb/subframe_doppler_test.sv
// Bench for subframe_doppler: two full frames, every output word compared
// with a spectrum computed arithmetically from the requirements.
module subframe_doppler_test;
    localparam int RB = 64;
    localparam int CH = 32;
    localparam int SL = 16;
    localparam int NS = RB * CH;
    localparam real PI = 3.14159265358979323846;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_iq = '0;
    logic        in_valid = 1'b0;
    logic        frame_start = 1'b0;
    logic [31:0] out_iq;
    logic        out_valid;
    logic [5:0]  out_range;
    logic [4:0]  out_bin;
    logic        frame_done;

    always #5 clk = ~clk;

    subframe_doppler uut (
        .clk (clk), .rst_n (rst_n), .in_iq (in_iq), .in_valid (in_valid),
        .frame_start (frame_start), .out_iq (out_iq), .out_valid (out_valid),
        .out_range (out_range), .out_bin (out_bin), .frame_done (frame_done)
    );

    int checks = 0;
    int errors = 0;
    logic signed [15:0] src_i [NS];
    logic signed [15:0] src_q [NS];
    logic signed [15:0] exp_i [NS];
    logic signed [15:0] exp_q [NS];
    logic [31:0]        cap   [NS];
    longint wtab [SL];
    longint ctab [SL];
    longint stab [SL];

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic longint rnd(input real v);
        if (v >= 0.0) return longint'($floor(v + 0.5));
        return -longint'($floor(-v + 0.5));
    endfunction

    function automatic longint bsat(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Coefficients straight from their definitions (R4, R5).
    task automatic build_tables();
        for (int n = 0; n < SL; n++) begin
            wtab[n] = rnd(32767.0 * (0.54 - 0.46 * $cos(2.0 * PI * n / 15.0)));
            ctab[n] = rnd(32767.0 * $cos(2.0 * PI * n / 16.0));
            stab[n] = rnd(32767.0 * $sin(2.0 * PI * n / 16.0));
        end
    endtask

    task automatic build_frame(input int kind);
        for (int c = 0; c < CH; c++) begin
            for (int r = 0; r < RB; r++) begin
                int a;
                longint vi, vq;
                real ang;
                a = c * RB + r;
                if (kind == 0) begin
                    case (r % 4)
                        0: begin
                            vi = longint'($urandom_range(8000)) - 4000;
                            vq = longint'($urandom_range(8000)) - 4000;
                        end
                        1: begin
                            ang = 2.0 * PI * ((r / 4) % 16) * c / 16.0;
                            vi = rnd(3000.0 * $cos(ang));
                            vq = rnd(3000.0 * $sin(ang));
                        end
                        2: begin
                            vi = r * 90 - 3000;
                            vq = 500;
                        end
                        default: begin
                            vi = (c == (r / 4) % CH) ? 8000 : 0;
                            vq = (c == (r / 4) % CH) ? -8000 : 0;
                        end
                    endcase
                end else if (r % 2 == 0) begin
                    vi = 32767;
                    vq = -32768;
                end else begin
                    vi = longint'($urandom_range(65535)) - 32768;
                    vq = longint'($urandom_range(65535)) - 32768;
                end
                src_i[a] = 16'(vi);
                src_q[a] = 16'(vq);
            end
        end
    endtask

    // Window, exact 16-point transform per sub-frame, round and clamp (R4, R6, R7).
    task automatic compute_expected();
        for (int r = 0; r < RB; r++) begin
            for (int b = 0; b < CH; b++) begin
                longint ar, ai, xi, xq, yi, yq;
                int sb, k, m, a;
                sb = b / SL;
                k  = b % SL;
                ar = 0;
                ai = 0;
                for (int n = 0; n < SL; n++) begin
                    a  = (sb * SL + n) * RB + r;
                    xi = src_i[a];
                    xq = src_q[a];
                    yi = bsat((xi * wtab[n] + 16384) >>> 15);
                    yq = bsat((xq * wtab[n] + 16384) >>> 15);
                    m  = (n * k) % SL;
                    ar += yi * ctab[m] + yq * stab[m];
                    ai += yq * ctab[m] - yi * stab[m];
                end
                exp_i[r * CH + b] = 16'(bsat((ar + 65536) >>> 17));
                exp_q[r * CH + b] = 16'(bsat((ai + 65536) >>> 17));
            end
        end
    endtask

    // Output monitor, sampled on the falling edge.
    int  cyc = 0;
    int  last_cyc = 0;
    int  out_idx = 0;
    int  frames_done = 0;
    bit  expect_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (expect_done) begin
                chk(frame_done == 1'b1, "R9 frame_done one cycle after last word", frame_done, 1);
                expect_done = 1'b0;
                out_idx = 0;
                frames_done++;
            end else if (frame_done) begin
                chk(1'b0, "R9 frame_done outside its slot", 1, 0);
            end
            if (out_valid) begin
                if (out_idx >= NS) begin
                    chk(1'b0, "R7 output word beyond 2048", out_idx, NS - 1);
                end else begin
                    int r, b;
                    r = out_idx / CH;
                    b = out_idx % CH;
                    chk(out_range == 6'(r), $sformatf("R7 range tag word %0d", out_idx), out_range, r);
                    chk(out_bin == 5'(b), $sformatf("R7 bin tag word %0d", out_idx), out_bin, b);
                    // R2 packing, R4 window, R5 twiddles feed this comparison.
                    chk($signed(out_iq[15:0]) == exp_i[out_idx],
                        $sformatf("R6 I range %0d bin %0d", r, b),
                        longint'($signed(out_iq[15:0])), longint'(exp_i[out_idx]));
                    chk($signed(out_iq[31:16]) == exp_q[out_idx],
                        $sformatf("R6 Q range %0d bin %0d", r, b),
                        longint'($signed(out_iq[31:16])), longint'(exp_q[out_idx]));
                    if (b % SL != 0)
                        chk(cyc - last_cyc == 17, $sformatf("R10 spacing before bin %0d", b),
                            cyc - last_cyc, 17);
                    cap[out_idx] = out_iq;
                    last_cyc = cyc;
                    out_idx++;
                    if (out_idx == NS) expect_done = 1'b1;
                end
            end
        end
    end

    task automatic send_frame(input int target_done);
        @(negedge clk);
        frame_start = 1'b1;
        in_valid    = 1'b1;
        in_iq       = 32'h1234_5678;
        for (int a = 0; a < NS; a++) begin
            if (a % 7 == 3) begin
                @(negedge clk);
                frame_start = 1'b0;
                in_valid    = 1'b0;
                in_iq       = 32'h0BAD_0BAD;
            end
            @(negedge clk);
            frame_start = 1'b0;
            in_valid    = 1'b1;
            in_iq       = {src_q[a], src_i[a]};
        end
        // Stray words while the frame is being processed (R3).
        @(negedge clk);
        in_valid = 1'b1;
        in_iq    = 32'h7FFF_8000;
        while (frames_done < target_done) @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: frames completed actual=%0d expected=2", frames_done);
        finish_run();
    end

    initial begin
        build_tables();
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid during reset", out_valid, 0);
        chk(frame_done == 1'b0, "R1 frame_done during reset", frame_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        chk(frame_done == 1'b0, "R1 frame_done after reset", frame_done, 0);

        // R3: words offered while idle must not enter the frame.
        for (int g = 0; g < 5; g++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_iq    = 32'($urandom);
        end

        build_frame(0);
        compute_expected();
        send_frame(1);

        // Second frame with full-scale inputs after idle stray words (R8, R9).
        repeat (3) @(negedge clk);
        in_valid = 1'b1;
        in_iq    = 32'hAAAA_5555;
        build_frame(1);
        compute_expected();
        send_frame(2);

        chk($signed(cap[0][15:0]) == 16'sd32767, "R8 I bin 0 full scale", $signed(cap[0][15:0]), 32767);
        chk($signed(cap[0][31:16]) == -16'sd32768, "R8 Q bin 0 full scale", $signed(cap[0][31:16]), -32768);
        chk($signed(cap[16][15:0]) == 16'sd32767, "R8 I bin 16 full scale", $signed(cap[16][15:0]), 32767);
        chk($signed(cap[16][31:16]) == -16'sd32768, "R8 Q bin 16 full scale", $signed(cap[16][31:16]), -32768);
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle after second frame", out_valid, 0);
        finish_run();
    end
endmodule